// File: doc/BRIEF.md
# Bus Transceiver Operating Mode Controller

This block is the digital control core of a single-wire bus transceiver. It tracks three operating modes (fail-safe, normal and sleep) and derives from them the enables for the external regulator inhibit switch and the bus termination. It also derives the two wake indications that the host microcontroller reads back on the receive and transmit pins. Its inputs come from the pin receivers and from the analog supervisors: the enable pin, the transmit input, a supply-present flag and an undervoltage flag. Wake detectors that have already filtered their inputs deliver single-cycle local and remote wake pulses. A one-cycle microsecond tick paces the mode-change filters and the delay of the inhibit switch at power-up.

The controller comes up in fail-safe. The host confirms normal operation by holding enable high through the filter time. It requests sleep by dropping enable while transmit is high. A wake event in sleep returns the controller to fail-safe. There it holds the wake request low on the receive pin and reports the wake source as a strong or weak pull-down on the transmit pin. Both wake indications vanish the moment enable goes high.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: After reset, or while supplyOn is low, mode is fail-safe (encoding 0; normal is 1, sleep is 2), rxdWakeLow is 0, wakeSrc is 0 and inhibitEn is 0.
- R2: inhibitEn first turns on at the clock edge of the INH_DELAY_TICKS-th usTick counted while supplyOn is high and underVolt is low. After that it is on in fail-safe and normal and off in sleep, and it is off whenever underVolt is high.
- R3: In fail-safe with underVolt low, the mode becomes normal at the edge of the FILT_TICKS-th tick counted with enable high. Enable low clears the count.
- R4: In normal, a falling edge of enable sampled while txdIn is high arms the sleep filter. The mode becomes sleep at the edge of the FILT_TICKS-th tick counted with enable low.
- R5: A falling edge of enable while txdIn is low has no effect, and the mode stays normal however long enable stays low.
- R6: If enable returns high before FILT_TICKS ticks after an armed falling edge, the request is dropped and the mode stays normal.
- R7: underVolt high forces the mode to fail-safe at the next clock edge from any mode.
- R8: In sleep, a wakeLocal or wakeRemote pulse moves the mode to fail-safe at the next edge and raises rxdWakeLow. wakeSrc becomes 1 for local (strong pull-down) and 2 for remote (weak pull-down), and local wins if both pulses arrive together.
- R9: rxdWakeLow and wakeSrc read 0 in the same cycle that enable is high, and they stay 0 after enable returns low.
- R10: termEn is 1 in fail-safe and normal and 0 in sleep.
- R11: Wake pulses outside sleep change neither the mode nor the wake indications.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| usTick | input | 1 | One-cycle pulse each microsecond |
| supplyOn | input | 1 | Supply above the power-up threshold |
| underVolt | input | 1 | Supply below the operating threshold |
| enable | input | 1 | Mode enable pin level |
| txdIn | input | 1 | Transmit input level |
| wakeLocal | input | 1 | Filtered local wake pulse |
| wakeRemote | input | 1 | Filtered bus wake pulse |
| mode | output | 2 | Current mode: 0 fail-safe, 1 normal, 2 sleep |
| inhibitEn | output | 1 | Inhibit high-side switch on |
| termEn | output | 1 | Bus termination on |
| rxdWakeLow | output | 1 | Hold receive pin low as wake request |
| wakeSrc | output | 2 | Transmit pin pull-down: 0 none, 1 strong (local), 2 weak (remote) |

## Verification
The bench builds the block with FILT_TICKS at 3 and INH_DELAY_TICKS at 5 instead of the defaults of 7 and 24. This makes both filters short enough to probe each one at one tick short of its limit and at the limit itself, within a few dozen cycles. At these values the count reset by an enable glitch, the dropped sleep request and the restart of the inhibit delay after a supply loss are each a handful of explicit ticks. The bench drives every tick itself, so each mode change lands on a known edge.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_FAILSAFE = 2'd0,
    MODE_NORMAL   = 2'd1,
    MODE_SLEEP    = 2'd2
  } mode_t;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_LOCAL  = 2'd1,
    SRC_REMOTE = 2'd2
  } wake_src_t;

  typedef struct packed {
    logic setLocal;
    logic setRemote;
  } wake_strobe_t;
endpackage

// File: rtl/xcvr_mode_fsm.sv
module xcvr_mode_fsm
  import xcvr_mode_pkg::*;
#(
  parameter int FILT_TICKS = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         usTick,
  input  logic         supplyOn,
  input  logic         underVolt,
  input  logic         enable,
  input  logic         txdIn,
  input  logic         wakeLocal,
  input  logic         wakeRemote,
  output mode_t        modeQ,
  output wake_strobe_t strobes
);
  localparam int FW = $clog2(FILT_TICKS + 1);
  localparam logic [FW-1:0] LAST = FW'(FILT_TICKS - 1);

  mode_t         modeD;
  logic [FW-1:0] cntQ, cntD;
  logic          armQ, armD;
  logic          enPrevQ;
  logic          supplyOk;

  assign supplyOk = supplyOn && !underVolt;

  always_comb begin
    modeD   = modeQ;
    cntD    = cntQ;
    armD    = armQ;
    strobes = '0;
    if (!supplyOk) begin
      modeD = MODE_FAILSAFE;
      cntD  = '0;
      armD  = 1'b0;
    end else begin
      unique case (modeQ)
        MODE_FAILSAFE: begin
          armD = 1'b0;
          if (!enable) cntD = '0;
          else if (usTick) begin
            if (cntQ == LAST) begin
              modeD = MODE_NORMAL;
              cntD  = '0;
            end else cntD = cntQ + 1'b1;
          end
        end
        MODE_NORMAL: begin
          if (enable) begin
            armD = 1'b0;
            cntD = '0;
          end else if (enPrevQ && txdIn && !armQ) begin
            armD = 1'b1;
            cntD = '0;
          end else if (armQ && usTick) begin
            if (cntQ == LAST) begin
              modeD = MODE_SLEEP;
              cntD  = '0;
              armD  = 1'b0;
            end else cntD = cntQ + 1'b1;
          end
        end
        MODE_SLEEP: begin
          cntD = '0;
          armD = 1'b0;
          if (wakeLocal || wakeRemote) begin
            modeD             = MODE_FAILSAFE;
            strobes.setLocal  = wakeLocal;
            strobes.setRemote = !wakeLocal;
          end
        end
        default: modeD = MODE_FAILSAFE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ   <= MODE_FAILSAFE;
      cntQ    <= '0;
      armQ    <= 1'b0;
      enPrevQ <= 1'b0;
    end else begin
      modeQ   <= modeD;
      cntQ    <= cntD;
      armQ    <= armD;
      enPrevQ <= enable;
    end
  end

  AST_UV_FORCES_FAILSAFE: assert property (@(posedge clk) disable iff (!rst_n)
    underVolt |=> modeQ == MODE_FAILSAFE) else $error("uv"); // R7

  AST_NORMAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_NORMAL && $past(modeQ) != MODE_NORMAL)
      |-> ($past(enable) && $past(usTick) && !$past(underVolt))) else $error("normal entry"); // R3

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_SLEEP && $past(modeQ) != MODE_SLEEP)
      |-> ($past(modeQ) == MODE_NORMAL && !$past(enable))) else $error("sleep entry"); // R4

  AST_WAKE_LEAVES_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_SLEEP && (wakeLocal || wakeRemote))
      |=> modeQ == MODE_FAILSAFE) else $error("wake"); // R8
endmodule

// File: rtl/xcvr_mode_dp.sv
module xcvr_mode_dp
  import xcvr_mode_pkg::*;
#(
  parameter int INH_DELAY_TICKS = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         usTick,
  input  logic         supplyOn,
  input  logic         underVolt,
  input  logic         enable,
  input  mode_t        modeQ,
  input  wake_strobe_t strobes,
  output logic         inhibitEn,
  output logic         termEn,
  output logic         rxdWakeLow,
  output wake_src_t    wakeSrc
);
  localparam int DW = $clog2(INH_DELAY_TICKS + 1);
  localparam logic [DW-1:0] DLAST = DW'(INH_DELAY_TICKS - 1);

  logic [DW-1:0] dlyQ;
  logic          upDoneQ;
  logic          reqQ;
  wake_src_t     srcQ;
  logic          anySet;

  assign anySet = strobes.setLocal || strobes.setRemote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlyQ    <= '0;
      upDoneQ <= 1'b0;
    end else if (!supplyOn) begin
      dlyQ    <= '0;
      upDoneQ <= 1'b0;
    end else if (!underVolt && !upDoneQ && usTick) begin
      if (dlyQ == DLAST) upDoneQ <= 1'b1;
      else dlyQ <= dlyQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqQ <= 1'b0;
      srcQ <= SRC_NONE;
    end else if (!supplyOn) begin
      reqQ <= 1'b0;
      srcQ <= SRC_NONE;
    end else if (anySet) begin
      reqQ <= 1'b1;
      srcQ <= strobes.setLocal ? SRC_LOCAL : SRC_REMOTE;
    end else if (enable) begin
      reqQ <= 1'b0;
      srcQ <= SRC_NONE;
    end
  end

  assign inhibitEn  = upDoneQ && !underVolt && (modeQ != MODE_SLEEP);
  assign termEn     = supplyOn && (modeQ != MODE_SLEEP);
  assign rxdWakeLow = reqQ && !enable;
  assign wakeSrc    = enable ? SRC_NONE : srcQ;

  AST_ENABLE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !anySet) |=> (!reqQ && srcQ == SRC_NONE)) else $error("clear"); // R9

  AST_SRC_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (srcQ != SRC_NONE) |-> reqQ) else $error("src"); // R8

  AST_INH_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upDoneQ) |-> ($past(usTick) && $past(supplyOn))) else $error("inh"); // R2
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import xcvr_mode_pkg::*;
#(
  parameter int FILT_TICKS      = 7,
  parameter int INH_DELAY_TICKS = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       usTick,
  input  logic       supplyOn,
  input  logic       underVolt,
  input  logic       enable,
  input  logic       txdIn,
  input  logic       wakeLocal,
  input  logic       wakeRemote,
  output logic [1:0] mode,
  output logic       inhibitEn,
  output logic       termEn,
  output logic       rxdWakeLow,
  output logic [1:0] wakeSrc
);
  mode_t        modeQ;
  wake_strobe_t strobes;
  wake_src_t    srcOut;

  xcvr_mode_fsm #(.FILT_TICKS(FILT_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .usTick(usTick), .supplyOn(supplyOn),
    .underVolt(underVolt), .enable(enable), .txdIn(txdIn),
    .wakeLocal(wakeLocal), .wakeRemote(wakeRemote),
    .modeQ(modeQ), .strobes(strobes)
  );

  xcvr_mode_dp #(.INH_DELAY_TICKS(INH_DELAY_TICKS)) u_dp (
    .clk(clk), .rst_n(rst_n), .usTick(usTick), .supplyOn(supplyOn),
    .underVolt(underVolt), .enable(enable), .modeQ(modeQ), .strobes(strobes),
    .inhibitEn(inhibitEn), .termEn(termEn), .rxdWakeLow(rxdWakeLow),
    .wakeSrc(srcOut)
  );

  assign mode    = modeQ;
  assign wakeSrc = srcOut;
endmodule

// File: tb/xcvr_mode_ctrl_tb.sv
module xcvr_mode_ctrl_tb;
  localparam int PERIOD = 10;
  localparam int FILT   = 3;
  localparam int INHD   = 5;

  logic clk = 0, rst_n = 0, usTick = 0, supplyOn = 1, underVolt = 0;
  logic enable = 0, txdIn = 1, wakeLocal = 0, wakeRemote = 0;
  logic [1:0] mode, wakeSrc;
  logic inhibitEn, termEn, rxdWakeLow;

  typedef struct {
    string      tag;
    logic [1:0] mode;
    logic       inh;
    logic       term;
    logic       rxd;
    logic [1:0] src;
  } exp_t;

  exp_t q[$];
  int vectors = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  xcvr_mode_ctrl #(.FILT_TICKS(FILT), .INH_DELAY_TICKS(INHD)) u_dut (
    .clk(clk), .rst_n(rst_n), .usTick(usTick), .supplyOn(supplyOn),
    .underVolt(underVolt), .enable(enable), .txdIn(txdIn),
    .wakeLocal(wakeLocal), .wakeRemote(wakeRemote), .mode(mode),
    .inhibitEn(inhibitEn), .termEn(termEn), .rxdWakeLow(rxdWakeLow),
    .wakeSrc(wakeSrc)
  );

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin usTick = 1; cyc(); usTick = 0; end
  endtask
  task automatic expect_(string tag, logic [1:0] m, logic inh, logic term,
                         logic rxd, logic [1:0] src);
    exp_t e;
    e.tag = tag; e.mode = m; e.inh = inh; e.term = term; e.rxd = rxd; e.src = src;
    q.push_back(e);
    @(negedge clk); #1;
  endtask

  // monitor: pops expectations and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        vectors++;
        if (mode !== e.mode || inhibitEn !== e.inh || termEn !== e.term ||
            rxdWakeLow !== e.rxd || wakeSrc !== e.src) begin
          errors++;
          $display("FAIL %s: got mode=%0d inh=%0d term=%0d rxd=%0d src=%0d exp mode=%0d inh=%0d term=%0d rxd=%0d src=%0d",
                   e.tag, mode, inhibitEn, termEn, rxdWakeLow, wakeSrc,
                   e.mode, e.inh, e.term, e.rxd, e.src);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung exp finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    cyc(); cyc(); rst_n = 1; cyc();
    expect_("R1", 0, 0, 1, 0, 0);
    tick(INHD - 1);
    expect_("R2", 0, 0, 1, 0, 0);
    tick(1);
    expect_("R2", 0, 1, 1, 0, 0);
    // R3: filter count cleared by enable low
    enable = 1; tick(FILT - 1);
    expect_("R3", 0, 1, 1, 0, 0);
    enable = 0; cyc(); enable = 1; tick(FILT - 1);
    expect_("R3", 0, 1, 1, 0, 0);
    tick(1);
    expect_("R3", 1, 1, 1, 0, 0);
    // R11: wake outside sleep ignored
    wakeLocal = 1; wakeRemote = 1; cyc(); wakeLocal = 0; wakeRemote = 0; cyc();
    enable = 0;
    expect_("R11", 1, 1, 1, 0, 0);
    enable = 1; cyc();
    // R5: fall with txd low
    txdIn = 0; enable = 0; cyc(); tick(FILT + 2);
    expect_("R5", 1, 1, 1, 0, 0);
    enable = 1; cyc(); txdIn = 1;
    // R6: short low pulse
    enable = 0; cyc(); tick(FILT - 1); enable = 1; cyc(); tick(FILT);
    expect_("R6", 1, 1, 1, 0, 0);
    // R4: sleep entry
    enable = 0; cyc(); tick(FILT - 1);
    expect_("R4", 1, 1, 1, 0, 0);
    tick(1);
    expect_("R4", 2, 0, 0, 0, 0);
    expect_("R10", 2, 0, 0, 0, 0);
    // R8: remote wake
    wakeRemote = 1; cyc(); wakeRemote = 0;
    expect_("R8", 0, 1, 1, 1, 2);
    cyc();
    expect_("R8", 0, 1, 1, 1, 2);
    enable = 1;
    expect_("R9", 0, 1, 1, 0, 0);
    cyc(); tick(FILT);
    expect_("R3", 1, 1, 1, 0, 0);
    enable = 0; cyc(); tick(FILT);
    expect_("R4", 2, 0, 0, 0, 0);
    wakeLocal = 1; wakeRemote = 1; cyc(); wakeLocal = 0; wakeRemote = 0;
    expect_("R8", 0, 1, 1, 1, 1);
    enable = 1; cyc(); enable = 0;
    expect_("R9", 0, 1, 1, 0, 0);
    // R7 from normal and from sleep
    enable = 1; tick(FILT);
    expect_("R3", 1, 1, 1, 0, 0);
    underVolt = 1; cyc();
    expect_("R7", 0, 0, 1, 0, 0);
    underVolt = 0; cyc();
    expect_("R2", 0, 1, 1, 0, 0);
    tick(FILT); enable = 0; cyc(); tick(FILT);
    expect_("R4", 2, 0, 0, 0, 0);
    underVolt = 1; cyc();
    expect_("R7", 0, 0, 1, 0, 0);
    underVolt = 0; cyc();
    // R1: supply loss restarts inhibit delay
    supplyOn = 0; cyc();
    expect_("R1", 0, 0, 0, 0, 0);
    supplyOn = 1; cyc();
    expect_("R1", 0, 0, 1, 0, 0);
    tick(INHD);
    expect_("R2", 0, 1, 1, 0, 0);
    cyc();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule